// File: doc/BRIEF.md
# Circular-Pool Register Renamer

The block renames the architected registers of an instruction trace without a free list or a map table. Each architected register owns a pool of physical slots that is used as a circular queue. The pools lie one after another in a single flat register file. Each pool has a length, and its base address is the sum of the lengths of the pools before it.

A destination write takes the next slot of its register's pool and advances that pool's index, wrapping to zero at the pool length. A source read returns the slot that was allocated last. Renaming runs in two registered stages. The first stage chooses the pool slot and captures the pool base. The second stage adds the base and the slot to form the flat register-file address, so results appear two cycles after the request.

A trace-start pulse and a trace-end pulse both return every index to zero, which is the fixed initial state. Pool lengths can be changed only between traces, and each change also returns every index to zero.

Top module: `pool_renamer`

## Requirements
- R1: After reset, no trace is active, both result valids are low, every pool has length DEF_LEN, pool i has base i*DEF_LEN, and every index is zero.
- R2: A source request accepted in cycle t gives srcAddrValid high in cycle t+2, with srcAddr = base of the named pool + that pool's current index.
- R3: A destination request accepted in cycle t gives dstAddrValid high in cycle t+2, with dstAddr = base + (index+1, or 0 when index+1 reaches the pool length). The pool's index then takes that value.
- R4: When the source and destination of one request name the same architected register, the source sees the index from before the increment.
- R5: Rename requests are accepted only while a trace is active. Outside a trace they produce no result and change no index.
- R6: traceStart makes the trace active from the next cycle and sets every index to zero. If traceStart and traceEnd are both high, start wins.
- R7: traceEnd without traceStart ends the trace and sets every index to zero. A rename request in that same cycle is still answered, using the indices from before the clear.
- R8: A resize request (pool resizeArch, new length resizeLen) is applied only when no trace is active and traceStart is low. It sets that pool's length, moves all bases to the new running sums, and sets every index to zero. Otherwise it is ignored.
- R9: A resize request is ignored when resizeLen is zero or when the new total of all pool lengths would exceed RF_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceStart | input | 1 | Begin a trace; indices to initial state |
| traceEnd | input | 1 | End a trace; indices restored to initial state |
| srcValid | input | 1 | Source rename request |
| srcArch | input | $clog2(NUM_ARCH) | Architected source register |
| dstValid | input | 1 | Destination rename request |
| dstArch | input | $clog2(NUM_ARCH) | Architected destination register |
| resizeValid | input | 1 | Pool length change request |
| resizeArch | input | $clog2(NUM_ARCH) | Pool to resize |
| resizeLen | input | $clog2(RF_DEPTH)+1 | New pool length |
| srcAddrValid | output | 1 | Source address valid |
| srcAddr | output | $clog2(RF_DEPTH) | Flat register-file address for the source |
| dstAddrValid | output | 1 | Destination address valid |
| dstAddr | output | $clog2(RF_DEPTH) | Flat register-file address for the destination |

## Verification
The bench builds the block with four architected registers, a 16-entry register file and a default pool length of 3. This keeps the default pools at 12 entries, so the index wraps after only three writes. A single resize can fill the file exactly to 16, and a slightly larger one overflows it and is rejected. Random resize lengths from 0 to 7 regularly reach both the zero-length rejection and the capacity limit, while the short pools produce frequent wraparound.

// File: rtl/pool_ren_pkg.sv
package pool_ren_pkg;
  typedef struct packed {
    logic clearIdx;   // return every pool index to the initial state
    logic incDst;     // advance the destination pool index
    logic doResize;   // write a new pool length
    logic capture;    // rename requests of this cycle are accepted
  } renStrobe_t;
endpackage

// File: rtl/pool_ren_ctrl.sv
module pool_ren_ctrl
  import pool_ren_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       traceStart,
  input  logic       traceEnd,
  input  logic       dstValid,
  input  logic       resizeValid,
  input  logic       resizeFits,
  output renStrobe_t strobe,
  output logic       traceActive
);
  logic activeQ;

  always_ff @(posedge clk) begin
    if (!rstN)           activeQ <= 1'b0;
    else if (traceStart) activeQ <= 1'b1;
    else if (traceEnd)   activeQ <= 1'b0;
  end

  always_comb begin
    strobe.capture  = activeQ;
    strobe.incDst   = activeQ & dstValid;
    strobe.doResize = resizeValid & ~activeQ & ~traceStart & resizeFits;
    strobe.clearIdx = traceStart | traceEnd | strobe.doResize;
  end

  assign traceActive = activeQ;
endmodule

// File: rtl/pool_ren_datapath.sv
module pool_ren_datapath
  import pool_ren_pkg::*;
#(
  parameter int NUM_ARCH = 4,
  parameter int RF_DEPTH = 32,
  parameter int DEF_LEN  = 4,
  localparam int ARCH_W = $clog2(NUM_ARCH),
  localparam int ADDR_W = $clog2(RF_DEPTH),
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  renStrobe_t        strobe,
  input  logic              srcValid,
  input  logic [ARCH_W-1:0] srcArch,
  input  logic [ARCH_W-1:0] dstArch,
  input  logic [ARCH_W-1:0] resizeArch,
  input  logic [LEN_W-1:0]  resizeLen,
  output logic              resizeFits,
  output logic              srcAddrValid,
  output logic [ADDR_W-1:0] srcAddr,
  output logic              dstAddrValid,
  output logic [ADDR_W-1:0] dstAddr
);
  localparam int SUM_W = LEN_W + ARCH_W + 1;

  logic [LEN_W-1:0]  lenQ    [NUM_ARCH];
  logic [ADDR_W-1:0] idxQ    [NUM_ARCH];
  logic [ADDR_W-1:0] baseC   [NUM_ARCH];
  logic [ADDR_W-1:0] nextIdx [NUM_ARCH];

  // Pool bases are running sums of the lengths; the next slot wraps at the length.
  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_pool
    logic [LEN_W-1:0] bumped;
    if (g == 0) begin : g_first
      assign baseC[g] = '0;
    end else begin : g_rest
      assign baseC[g] = baseC[g-1] + lenQ[g-1][ADDR_W-1:0];
    end
    assign bumped     = {1'b0, idxQ[g]} + LEN_W'(1);
    assign nextIdx[g] = (bumped >= lenQ[g]) ? '0 : bumped[ADDR_W-1:0];
  end

  // Capacity check of a requested resize.
  always_comb begin
    logic [SUM_W-1:0] total;
    total = '0;
    for (int i = 0; i < NUM_ARCH; i++) begin
      if (ARCH_W'(i) == resizeArch) total = total + SUM_W'(resizeLen);
      else                          total = total + SUM_W'(lenQ[i]);
    end
    resizeFits = (resizeLen != '0) && (total <= SUM_W'(RF_DEPTH));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ARCH; i++) begin
      if (!rstN) begin
        lenQ[i] <= LEN_W'(DEF_LEN);
        idxQ[i] <= '0;
      end else begin
        if (strobe.clearIdx)                           idxQ[i] <= '0;
        else if (strobe.incDst && dstArch == ARCH_W'(i)) idxQ[i] <= nextIdx[i];
        if (strobe.doResize && resizeArch == ARCH_W'(i)) lenQ[i] <= resizeLen;
      end
    end
  end

  // Stage 1: pool slot and base; stage 2: flat address.
  logic              s1SrcV, s1DstV;
  logic [ADDR_W-1:0] s1SrcBase, s1SrcSlot, s1DstBase, s1DstSlot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1SrcV       <= 1'b0;
      s1DstV       <= 1'b0;
      s1SrcBase    <= '0;
      s1SrcSlot    <= '0;
      s1DstBase    <= '0;
      s1DstSlot    <= '0;
      srcAddrValid <= 1'b0;
      dstAddrValid <= 1'b0;
      srcAddr      <= '0;
      dstAddr      <= '0;
    end else begin
      s1SrcV       <= strobe.capture & srcValid;
      s1SrcBase    <= baseC[srcArch];
      s1SrcSlot    <= idxQ[srcArch];
      s1DstV       <= strobe.incDst;
      s1DstBase    <= baseC[dstArch];
      s1DstSlot    <= nextIdx[dstArch];
      srcAddrValid <= s1SrcV;
      srcAddr      <= s1SrcBase + s1SrcSlot;
      dstAddrValid <= s1DstV;
      dstAddr      <= s1DstBase + s1DstSlot;
    end
  end
endmodule

// File: rtl/pool_renamer.sv
module pool_renamer
  import pool_ren_pkg::*;
#(
  parameter int NUM_ARCH = 4,
  parameter int RF_DEPTH = 32,
  parameter int DEF_LEN  = 4,
  localparam int ARCH_W = $clog2(NUM_ARCH),
  localparam int ADDR_W = $clog2(RF_DEPTH),
  localparam int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceStart,
  input  logic              traceEnd,
  input  logic              srcValid,
  input  logic [ARCH_W-1:0] srcArch,
  input  logic              dstValid,
  input  logic [ARCH_W-1:0] dstArch,
  input  logic              resizeValid,
  input  logic [ARCH_W-1:0] resizeArch,
  input  logic [LEN_W-1:0]  resizeLen,
  output logic              srcAddrValid,
  output logic [ADDR_W-1:0] srcAddr,
  output logic              dstAddrValid,
  output logic [ADDR_W-1:0] dstAddr
);
  renStrobe_t strobe;
  logic       traceActive;
  logic       resizeFits;
  logic       resizeTaken;

  pool_ren_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .traceStart(traceStart), .traceEnd(traceEnd),
    .dstValid(dstValid), .resizeValid(resizeValid), .resizeFits(resizeFits),
    .strobe(strobe), .traceActive(traceActive)
  );

  pool_ren_datapath #(.NUM_ARCH(NUM_ARCH), .RF_DEPTH(RF_DEPTH), .DEF_LEN(DEF_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcValid(srcValid),
    .srcArch(srcArch), .dstArch(dstArch), .resizeArch(resizeArch),
    .resizeLen(resizeLen), .resizeFits(resizeFits),
    .srcAddrValid(srcAddrValid), .srcAddr(srcAddr),
    .dstAddrValid(dstAddrValid), .dstAddr(dstAddr)
  );

  assign resizeTaken = strobe.doResize;
endmodule

// File: rtl/pool_ren_chk.sv
module pool_ren_chk (
  input logic clk,
  input logic rstN,
  input logic traceStart,
  input logic traceEnd,
  input logic srcValid,
  input logic dstValid,
  input logic resizeValid,
  input logic traceActive,
  input logic resizeTaken,
  input logic srcAddrValid,
  input logic dstAddrValid
);
  p_src_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    srcAddrValid |-> ($past(srcValid, 2) && $past(traceActive, 2)));

  p_dst_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    dstAddrValid |-> ($past(dstValid, 2) && $past(traceActive, 2)));

  p_start_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    traceStart |=> traceActive);

  p_end_stops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (traceEnd && !traceStart) |=> !traceActive);

  p_resize_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    resizeTaken |-> (resizeValid && !traceActive && !traceStart));
endmodule

bind pool_renamer pool_ren_chk u_chk (
  .clk(clk), .rstN(rstN), .traceStart(traceStart), .traceEnd(traceEnd),
  .srcValid(srcValid), .dstValid(dstValid), .resizeValid(resizeValid),
  .traceActive(traceActive), .resizeTaken(resizeTaken),
  .srcAddrValid(srcAddrValid), .dstAddrValid(dstAddrValid)
);

// File: tb/tb_pool_renamer.sv
module tb_pool_renamer;
  localparam int NA = 4, RFD = 16, DL = 3;
  localparam int AW = 2, DW = 4, LW = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic traceStart = 0, traceEnd = 0, srcValid = 0, dstValid = 0, resizeValid = 0;
  logic [AW-1:0] srcArch = '0, dstArch = '0, resizeArch = '0;
  logic [LW-1:0] resizeLen = '0;
  logic srcAddrValid, dstAddrValid;
  logic [DW-1:0] srcAddr, dstAddr;

  always #4 clk = ~clk;

  pool_renamer #(.NUM_ARCH(NA), .RF_DEPTH(RFD), .DEF_LEN(DL)) dut (.*);

  int total = 0, bad = 0;
  string reqTag = "R1";
  int mLen[NA], mIdx[NA];
  bit mAct;
  bit p0sv, p0dv, p1sv, p1dv;
  int p0s, p0d, p1s, p1d;

  function automatic int mBase(int a);
    int b = 0;
    for (int i = 0; i < a; i++) b += mLen[i];
    return b;
  endfunction

  function automatic int mNext(int a);
    return (mIdx[a] + 1 >= mLen[a]) ? 0 : mIdx[a] + 1;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", reqTag, what, act, exp);
    end
  endtask

  task automatic cyc(bit st, bit en, bit sv, int sa, bit dv, int da, bit rv, int ra, int rl);
    bit doRes;
    int tot;
    @(negedge clk);
    chk(srcAddrValid == p1sv, "srcAddrValid", srcAddrValid, p1sv);
    chk(dstAddrValid == p1dv, "dstAddrValid", dstAddrValid, p1dv);
    if (p1sv) chk(srcAddr == DW'(p1s), "srcAddr", srcAddr, p1s);
    if (p1dv) chk(dstAddr == DW'(p1d), "dstAddr", dstAddr, p1d);
    p1sv = p0sv; p1dv = p0dv; p1s = p0s; p1d = p0d;
    p0sv = mAct && sv; p0s = mBase(sa) + mIdx[sa];
    p0dv = mAct && dv; p0d = mBase(da) + mNext(da);
    traceStart = st; traceEnd = en; srcValid = sv; srcArch = AW'(sa);
    dstValid = dv; dstArch = AW'(da); resizeValid = rv;
    resizeArch = AW'(ra); resizeLen = LW'(rl);
    tot = 0;
    for (int i = 0; i < NA; i++) tot += (i == ra) ? rl : mLen[i];
    doRes = rv && !mAct && !st && rl != 0 && tot <= RFD;
    if (st || en || doRes) for (int i = 0; i < NA; i++) mIdx[i] = 0;
    else if (mAct && dv) mIdx[da] = mNext(da);
    if (doRes) mLen[ra] = rl;
    if (st) mAct = 1; else if (en) mAct = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) begin mLen[i] = DL; mIdx[i] = 0; end
    mAct = 0; p0sv = 0; p0dv = 0; p1sv = 0; p1dv = 0;
    p0s = 0; p0d = 0; p1s = 0; p1d = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: outputs quiet after reset, default bases seen on first trace
    reqTag = "R1"; idle(3);
    // R5: requests outside a trace give nothing and leave indices alone
    reqTag = "R5"; cyc(0, 0, 1, 1, 1, 1, 0, 0, 0); cyc(0, 0, 1, 2, 1, 2, 0, 0, 0); idle(2);
    reqTag = "R6"; cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    reqTag = "R2"; cyc(0, 0, 1, 1, 0, 0, 0, 0, 0); cyc(0, 0, 1, 3, 0, 0, 0, 0, 0);
    // R3: three writes into a length-3 pool wrap back to slot 0
    reqTag = "R3"; for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1, 1, 0, 0, 0);
    // R4: same register as source and destination sees the old index
    reqTag = "R4"; cyc(0, 0, 1, 1, 1, 1, 0, 0, 0); cyc(0, 0, 1, 1, 1, 1, 0, 0, 0);
    // R7: rename in end cycle is answered, indices restored afterwards
    reqTag = "R7"; cyc(0, 0, 0, 0, 1, 2, 0, 0, 0); cyc(0, 1, 1, 2, 1, 2, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 1, 2, 0, 0, 0, 0, 0);
    reqTag = "R6"; cyc(0, 0, 0, 0, 1, 0, 0, 0, 0); cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 1, 0, 0, 0, 0);
    // R8: resize during a trace is ignored; idle resize moves bases
    reqTag = "R8"; cyc(0, 0, 0, 0, 0, 0, 1, 0, 7); cyc(0, 0, 1, 3, 1, 3, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0, 0, 1, 0, 7);
    cyc(0, 0, 1, 3, 0, 0, 0, 0, 0); cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 7); cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 3, 1, 3, 0, 0, 0); cyc(0, 0, 1, 1, 1, 0, 0, 0, 0);
    // R9: zero length and overflow of the file are rejected
    reqTag = "R9"; cyc(0, 1, 0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 1, 1, 4);
    cyc(0, 0, 0, 0, 0, 0, 1, 2, 0); cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 3, 1, 2, 0, 0, 0); cyc(0, 0, 1, 1, 0, 0, 0, 0, 0);
    // random mix over R2/R3/R4/R5/R6/R7/R8/R9
    reqTag = "random";
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      cyc(($urandom % 16) == 0, ($urandom % 16) == 0,
          $urandom % 2, $urandom % NA, $urandom % 2, $urandom % NA,
          ($urandom % 6) == 0, $urandom % NA, $urandom % 8);
    end
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule